// File: doc/BRIEF.md
# Switchable PRG Bank Mapper

This block translates CPU accesses in the 32 KB program ROM window (0x8000–0xFFFF) into a flat program ROM byte address. The window is split into two 16 KB slots, selected by CPU address bit 14. One slot always shows a fixed bank. The other slot shows the bank held in a bank register. A CPU write anywhere in the window loads that register. The stored value is cut to the number of bits the ROM size needs: the bank count is rounded up to a power of two, and that power of two minus one is the mask.

A build parameter picks one of two layouts. In the fixed-last layout, the lower slot is switchable and the upper slot holds the last ROM bank. In the fixed-first layout, the lower slot holds bank 0 and the upper slot is switchable. A variant parameter controls AND-type bus conflicts. When they are on, the value stored is the CPU data ANDed with the ROM byte visible at the write address, which the system returns on `rom_data_i`. Variant value 2 turns conflicts off; every other value leaves them on.

Graphics memory is a plain, unbanked RAM on its own port. Its depth is 2^CHR_AW bytes, so the full 8 KB needs CHR_AW = 13. The default is kept smaller.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset (asynchronous, active low), the bank register holds 0, so the switchable slot shows bank 0.
- R2: For any CPU address with bit 15 set, `prg_addr_o[13:0]` equals `cpu_addr_i[13:0]`, and `prg_addr_o` equals bank × 16384 + offset for the bank shown in the slot that CPU address bit 14 selects.
- R3: With FIXED_LAST = 1, addresses 0x8000–0xBFFF show the register bank, and addresses 0xC000–0xFFFF always show bank ROM_BANKS−1, whatever has been written.
- R4: With FIXED_LAST = 0, addresses 0x8000–0xBFFF always show bank 0, and addresses 0xC000–0xFFFF show the register bank, whatever has been written.
- R5: On a clock edge where `cpu_wr_i` = 1 and `cpu_addr_i[15]` = 1, the register loads the effective write value ANDed with 2^ceil(log2(ROM_BANKS))−1. The new bank is visible from that edge on.
- R6: When BUS_VARIANT ≠ 2, the effective write value is `cpu_data_i & rom_data_i`. When BUS_VARIANT = 2, it is `cpu_data_i` unchanged.
- R7: A write with `cpu_addr_i[15]` = 0 leaves the bank register unchanged.
- R8: With ROM_BANKS = 1, the mask is 0, and both slots show bank 0 for any write.
- R9: The graphics RAM stores `chr_wdata_i` at `chr_addr_i` on a clock edge where `chr_wr_i` = 1. `chr_rdata_o` gives the byte at the address presented one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe |
| rom_data_i | input | 8 | Program ROM byte at the current `prg_addr_o` |
| prg_addr_o | output | PRG_AW | Translated program ROM byte address |
| chr_addr_i | input | CHR_AW | Graphics RAM address |
| chr_wr_i | input | 1 | Graphics RAM write strobe |
| chr_wdata_i | input | 8 | Graphics RAM write data |
| chr_rdata_o | output | 8 | Graphics RAM read data, registered |

## Verification
The hardest case to reach is a bus conflict where the ROM byte clears bits that the CPU tried to set. The stored bank then depends on what the ROM shows at the write address, not only on the data written. The bench models the ROM so that its byte equals the low byte of the offset. It then sweeps every data value against sixteen write-address low bytes, so the AND pattern covers all bit combinations. A fixed-first instance with conflicts off and a single-bank instance get the same writes, so the register mask, the fixed slots and the variant switch are checked against one another.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int unsigned BANK_OFS_W = 14;  // 16 KB bank

  typedef enum logic {SLOT_LO = 1'b0, SLOT_HI = 1'b1} slot_e;

  function automatic int unsigned sel_width(input int unsigned banks);
    return (banks > 1) ? $clog2(banks) : 1;
  endfunction

  function automatic int unsigned sel_mask(input int unsigned banks);
    return (1 << $clog2(banks)) - 1;
  endfunction
endpackage

// File: rtl/prg_bank_reg.sv
module prg_bank_reg #(
  parameter int unsigned BW       = 3,
  parameter int unsigned MASK     = 7,
  parameter bit          CONFLICT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [7:0]    data_i,
  input  logic [7:0]    rom_i,
  output logic [BW-1:0] bank_o
);
  localparam logic [7:0] MASK8 = 8'(MASK);

  logic [7:0]    eff;
  logic [BW-1:0] nxt;

  // AND-type conflict: the ROM drives the bus during the write
  assign eff = CONFLICT ? (data_i & rom_i) : data_i;
  assign nxt = BW'(eff & MASK8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bank_o <= '0;
    else if (ld_i) bank_o <= nxt;
  end
endmodule

// File: rtl/prg_addr_map.sv
module prg_addr_map
  import prg_map_pkg::*;
#(
  parameter int unsigned BW         = 3,
  parameter bit          FIXED_LAST = 1'b1,
  parameter int unsigned LAST_BANK  = 7
) (
  input  logic [14:0]              addr_i,
  input  logic [BW-1:0]            bank_i,
  output logic [BW+BANK_OFS_W-1:0] rom_addr_o
);
  localparam logic [BW-1:0] FIXED = FIXED_LAST ? BW'(LAST_BANK) : '0;

  slot_e         slot;
  logic [BW-1:0] shown;

  assign slot = slot_e'(addr_i[14]);

  generate
    if (FIXED_LAST) begin : g_fixed_last
      assign shown = (slot == SLOT_HI) ? FIXED : bank_i;
    end else begin : g_fixed_first
      assign shown = (slot == SLOT_LO) ? FIXED : bank_i;
    end
  endgenerate

  assign rom_addr_o = {shown, addr_i[BANK_OFS_W-1:0]};
endmodule

// File: rtl/chr_ram.sv
module chr_ram #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int unsigned ROM_BANKS   = 8,
  parameter bit          FIXED_LAST  = 1'b1,
  parameter int unsigned BUS_VARIANT = 0,
  parameter int unsigned CHR_AW      = 11,
  localparam int unsigned BW         = sel_width(ROM_BANKS),
  localparam int unsigned PRG_AW     = BW + BANK_OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_wr_i,
  input  logic [7:0]        rom_data_i,
  output logic [PRG_AW-1:0] prg_addr_o,
  input  logic [CHR_AW-1:0] chr_addr_i,
  input  logic              chr_wr_i,
  input  logic [7:0]        chr_wdata_i,
  output logic [7:0]        chr_rdata_o
);
  localparam int unsigned MASK     = sel_mask(ROM_BANKS);
  localparam bit          CONFLICT = (BUS_VARIANT != 2);

  logic          bank_ld;
  logic [BW-1:0] sel_bank;

  assign bank_ld = cpu_wr_i & cpu_addr_i[15];

  prg_bank_reg #(
    .BW(BW), .MASK(MASK), .CONFLICT(CONFLICT)
  ) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (bank_ld),
    .data_i(cpu_data_i),
    .rom_i (rom_data_i),
    .bank_o(sel_bank)
  );

  prg_addr_map #(
    .BW(BW), .FIXED_LAST(FIXED_LAST), .LAST_BANK(ROM_BANKS - 1)
  ) u_map (
    .addr_i    (cpu_addr_i[14:0]),
    .bank_i    (sel_bank),
    .rom_addr_o(prg_addr_o)
  );

  chr_ram #(.AW(CHR_AW)) u_chr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (chr_wr_i),
    .addr_i (chr_addr_i),
    .wdata_i(chr_wdata_i),
    .rdata_o(chr_rdata_o)
  );
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int unsigned ROM_BANKS   = 8,
  parameter bit          FIXED_LAST  = 1'b1,
  parameter int unsigned BUS_VARIANT = 0,
  parameter int unsigned BW          = 3,
  parameter int unsigned PRG_AW      = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       cpu_addr_i,
  input logic [7:0]        cpu_data_i,
  input logic              cpu_wr_i,
  input logic [7:0]        rom_data_i,
  input logic [PRG_AW-1:0] prg_addr_o,
  input logic [BW-1:0]     sel_bank
);
  localparam logic [BW-1:0] LAST = BW'(ROM_BANKS - 1);
  localparam logic [BW-1:0] MSK  = BW'((1 << $clog2(ROM_BANKS)) - 1);
  localparam bit            CONF = (BUS_VARIANT != 2);

  p_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15] |-> prg_addr_o[13:0] == cpu_addr_i[13:0]);

  p_hi_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (FIXED_LAST && cpu_addr_i[15:14] == 2'b11) |-> prg_addr_o[PRG_AW-1:14] == LAST);

  p_lo_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!FIXED_LAST && cpu_addr_i[15:14] == 2'b10) |-> prg_addr_o[PRG_AW-1:14] == '0);

  p_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_bank & ~MSK) == '0);

  p_conflict_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CONF && cpu_wr_i && cpu_addr_i[15])
      |=> (sel_bank & ~BW'($past(cpu_data_i & rom_data_i))) == '0);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_wr_i && cpu_addr_i[15]) |=> $stable(sel_bank));
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
  .ROM_BANKS(ROM_BANKS), .FIXED_LAST(FIXED_LAST), .BUS_VARIANT(BUS_VARIANT),
  .BW(BW), .PRG_AW(PRG_AW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cpu_addr_i(cpu_addr_i),
  .cpu_data_i(cpu_data_i),
  .cpu_wr_i  (cpu_wr_i),
  .rom_data_i(rom_data_i),
  .prg_addr_o(prg_addr_o),
  .sel_bank  (sel_bank)
);

// File: tb/prg_bank_mapper_test.sv
`timescale 1ns/1ps
module prg_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [10:0] chr_addr = '0;
  logic        chr_wr = 1'b0;
  logic [7:0]  chr_wdata = 8'h00;

  logic [16:0] pa_a, pa_f;
  logic [14:0] pa_o;
  logic [7:0]  rd_a, rd_f, rd_o;
  logic [7:0]  rom_a, rom_f, rom_o;

  int vectors = 0;
  int miscompares = 0;
  int exp_a = 0;
  int exp_f = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // ROM model: byte equals low byte of the offset
  assign rom_a = pa_a[7:0];
  assign rom_f = pa_f[7:0];
  assign rom_o = pa_o[7:0];

  // 6 banks, fixed last, conflicts on
  prg_bank_mapper #(.ROM_BANKS(6), .FIXED_LAST(1'b1), .BUS_VARIANT(0), .CHR_AW(11)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .cpu_data_i(cpu_data),
    .cpu_wr_i(cpu_wr), .rom_data_i(rom_a), .prg_addr_o(pa_a),
    .chr_addr_i(chr_addr), .chr_wr_i(chr_wr), .chr_wdata_i(chr_wdata), .chr_rdata_o(rd_a));

  // 8 banks, fixed first, conflicts off
  prg_bank_mapper #(.ROM_BANKS(8), .FIXED_LAST(1'b0), .BUS_VARIANT(2), .CHR_AW(11)) uut_ff (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .cpu_data_i(cpu_data),
    .cpu_wr_i(cpu_wr), .rom_data_i(rom_f), .prg_addr_o(pa_f),
    .chr_addr_i(chr_addr), .chr_wr_i(chr_wr), .chr_wdata_i(chr_wdata), .chr_rdata_o(rd_f));

  // single bank
  prg_bank_mapper #(.ROM_BANKS(1), .FIXED_LAST(1'b1), .BUS_VARIANT(0), .CHR_AW(11)) uut_one (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .cpu_data_i(cpu_data),
    .cpu_wr_i(cpu_wr), .rom_data_i(rom_o), .prg_addr_o(pa_o),
    .chr_addr_i(chr_addr), .chr_wr_i(chr_wr), .chr_wdata_i(chr_wdata), .chr_rdata_o(rd_o));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // probe all slots of all instances at a given offset
  task automatic probe(input int off, input string tag);
    cpu_addr = 16'(32'h8000 | off);
    #1;
    chk({tag, " R3 lower a"}, int'(pa_a), exp_a * 16384 + off);
    chk({tag, " R4 lower f"}, int'(pa_f), off);
    chk({tag, " R8 lower one"}, int'(pa_o), off);
    cpu_addr = 16'(32'hC000 | off);
    #1;
    chk({tag, " R3 upper a"}, int'(pa_a), 5 * 16384 + off);
    chk({tag, " R4 upper f"}, int'(pa_f), exp_f * 16384 + off);
    chk({tag, " R8 upper one"}, int'(pa_o), off);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    cpu_data = d;
    cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    probe(16'h0123, "R1 reset");
    chk("R2 offset passthrough", int'(pa_a[13:0]), 16'h0123 & 16'h3FFF);

    // R5 R6 sweep: all data values x 16 ROM byte patterns
    for (int d = 0; d < 256; d++) begin
      for (int k = 0; k < 16; k++) begin
        int lo = k * 17;
        logic [15:0] a;
        a = 16'(32'h8000 | ((k & 1) << 14) | ((d & 63) << 8) | lo);
        do_write(a, 8'(d));
        exp_a = (d & lo) & 7;   // R6 conflict, R5 mask 7
        exp_f = d & 7;          // R6 variant 2: no conflict
        probe((d * 37 + k * 1021) & 16'h3FFF, "R5/R6");
      end
      if ((d & 15) == 5) begin
        // R7 write below 0x8000 ignored
        do_write(16'((d << 7) & 16'h7FFF), ~8'(d));
        probe(16'h3FFF, "R7 ignored");
      end
    end

    // R2 offset corners
    probe(0, "R2 off0");
    probe(16'h3FFF, "R2 offmax");

    // R1 async reset clears a nonzero bank
    do_write(16'h80FF, 8'hFF);
    exp_a = 7; exp_f = 7;
    probe(16'h0010, "R5 bank7");
    rst_n = 1'b0;
    #1;
    exp_a = 0; exp_f = 0;
    probe(16'h0010, "R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 graphics RAM: fill then read back
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk);
      chr_addr = 11'(i);
      chr_wdata = 8'((i * 7 + 3) ^ (i >> 3));
      chr_wr = 1'b1;
    end
    @(negedge clk);
    chr_wr = 1'b0;
    for (int i = 0; i < 2048; i++) begin
      chr_addr = 11'(i);
      @(negedge clk);
      chk("R9 chr readback", int'(rd_a), ((i * 7 + 3) ^ (i >> 3)) & 255);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule